// File: doc/BRIEF.md
# Byte-Bus Serial Port with Receive Queue

This block is a small asynchronous serial port that a processor reaches through a byte-wide register bus. Every register sits on a word boundary and carries eight bits. Software programs a 16-bit clock divisor and writes bytes to a data register for transmission. It reads received bytes back through the same data register. A combined status/control register reports the queue and transmitter state, holds two interrupt enables, and keeps two sticky receive error flags.

Frames are always one start bit, eight data bits sent least significant bit first, and one stop bit. There is no parity, no flow control, no modem lines and no break. The divisor value D gives a sampling tick every D+1 clocks, so one bit lasts four ticks, and D is chosen as clk/(4*baud)-1. Received bytes wait in a four-entry queue. The transmitter holds a single byte. One interrupt line combines a receive cause and a transmit cause.

Top module: `sio_port`

## Requirements
- R1: After reset, the status register reads 0xA0 (transmit empty bit7 and receive empty bit5 set, every other bit clear), both divisor bytes read 0, irq is 0 and txd is 1.
- R2: Byte offsets 0, 4, 8 and 12 return the fixed identification bytes given by parameters (defaults 0x53, 0x49, 0x4F, 0x01), and writes to them change nothing. An access whose two low address bits are not zero is ignored.
- R3: Offsets 24 and 28 hold the low and high divisor bytes and read back as written. With divisor D, a tick occurs every D+1 clocks and each bit lasts 4 ticks.
- R4: A write to DATA (offset 16) while status bit7 is 1 sends the byte as a frame: txd goes low for the start bit, then carries the data bits LSB first, then a high stop bit. Bit7 stays 0 until the stop bit ends. A DATA write while bit7 is 0 is ignored, and txd is 1 whenever no frame is in progress.
- R5: A received frame puts its byte in the queue. A DATA read returns the oldest byte and removes it. A DATA read of an empty queue returns 0 and leaves the queue unchanged.
- R6: Status bit5 is 1 when the queue is empty, bit4 is 1 when it holds exactly 3 bytes, and bit3 is 1 when it holds 4 bytes.
- R7: A frame that completes while the queue is full sets the overrun flag (status bit1), and its byte is dropped.
- R8: A frame whose stop bit is sampled low sets the framing flag (status bit0). Its byte is still queued.
- R9: A status write clears an error flag where the written bit is 0 and leaves it as it is where the written bit is 1. Bits 2 (receive interrupt enable) and 6 (transmit interrupt enable) take the written value. Bits 3, 4, 5 and 7 ignore writes.
- R10: irq is 1 exactly when (bit2 and (queue not empty or an error flag set)) or (bit6 and bit7).
- R11: A falling edge on rxd starts a frame only if rxd is still low two ticks later. A shorter low pulse queues nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; a DATA read pops at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, valid in the cycle of the strobe |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that bus_wr and bus_rd are never high in the same cycle and that the status register changes only through bus writes. The flag and enable hold properties depend on both points. They also assume that rxd changes only on bit boundaries that are at least one bit time apart. The stimulus keeps to these assumptions. It issues one strobe per cycle from tasks that change inputs on the falling clock edge. It drives rxd for whole bit periods of sixteen clocks, matching a divisor of 3, and holds it high between frames. The one exception is the deliberate short glitch used for start confirmation.

// File: rtl/sio_pkg.sv
// Package: shared register selectors, status bit positions and receiver states
// for the serial port. Assumes a 5-bit byte address with word-aligned registers.
package sio_pkg;

    localparam int BUS_ADDR_W = 5;
    localparam int BYTE_W     = 8;

    typedef enum logic [2:0] {
        SEL_ID0   = 3'd0,
        SEL_ID1   = 3'd1,
        SEL_ID2   = 3'd2,
        SEL_ID3   = 3'd3,
        SEL_DATA  = 3'd4,
        SEL_STAT  = 3'd5,
        SEL_DIVLO = 3'd6,
        SEL_DIVHI = 3'd7
    } reg_sel_e;

    // Status bit positions (software decodes them, so they are fixed)
    localparam int ST_FERR  = 0;
    localparam int ST_OERR  = 1;
    localparam int ST_RXIE  = 2;
    localparam int ST_FULL  = 3;
    localparam int ST_ONE   = 4;
    localparam int ST_EMPTY = 5;
    localparam int ST_TXIE  = 6;
    localparam int ST_TXE   = 7;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/sio_baud_gen.sv
// Tick generator: emits a one-clock tick every divisor+1 clocks.
// Assumes the divisor may change at any time; a lowered divisor takes effect
// at once because the count is compared with >=.
module sio_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    // Count clocks up to the divisor and pulse the tick on wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= divisor) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end

endmodule

// File: rtl/sio_tx.sv
// Transmitter: takes one byte when idle and shifts out start, data (LSB
// first) and stop bits, OSR ticks per bit. Assumes load is a one-cycle pulse;
// a load while busy is dropped.
module sio_tx #(
    parameter int DATA_W = 8,
    parameter int OSR    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              busy,
    output logic              txd
);

    localparam int FRAME_BITS = DATA_W + 2;
    localparam int SUB_W      = (OSR > 1) ? $clog2(OSR) : 1;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shreg_q;
    logic [SUB_W-1:0]      sub_q;
    logic [BIT_W-1:0]      nbit_q;
    logic                  busy_q;

    // Load a frame when idle, then shift one bit per OSR ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '1;
            sub_q   <= '0;
            nbit_q  <= '0;
            busy_q  <= 1'b0;
        end else if (load && !busy_q) begin
            shreg_q <= {1'b1, load_data, 1'b0};
            sub_q   <= '0;
            nbit_q  <= '0;
            busy_q  <= 1'b1;
        end else if (busy_q && tick) begin
            if (sub_q == SUB_LAST) begin
                sub_q   <= '0;
                shreg_q <= {1'b1, shreg_q[FRAME_BITS-1:1]};
                if (nbit_q == BIT_LAST) begin
                    busy_q <= 1'b0;
                end else begin
                    nbit_q <= nbit_q + 1'b1;
                end
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign txd  = busy_q ? shreg_q[0] : 1'b1;

endmodule

// File: rtl/sio_rx.sv
// Receiver: synchronises rxd, waits for a falling edge, confirms the start
// bit OSR/2 ticks later, then samples every OSR ticks. Pulses done with the
// byte and a framing flag after the stop bit. Assumes rxd is asynchronous.
module sio_rx #(
    parameter int DATA_W = 8,
    parameter int OSR    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              ferr
);

    import sio_pkg::*;

    localparam int SUB_W = (OSR > 1) ? $clog2(OSR) : 1;
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST  = SUB_W'(OSR - 1);
    localparam logic [SUB_W-1:0] HALF_LAST = SUB_W'(OSR / 2 - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_W - 1);

    logic              sync1_q, sync2_q, prev_q;
    logic              fall;
    rx_state_e         state_q;
    logic [SUB_W-1:0]  tcnt_q;
    logic [BIT_W-1:0]  bcnt_q;
    logic [DATA_W-1:0] shreg_q;

    // Two-flop synchroniser plus previous value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
            prev_q  <= 1'b1;
        end else begin
            sync1_q <= rxd;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign fall = prev_q && !sync2_q;

    // Frame state machine: start confirmation, data shift, stop check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            tcnt_q  <= '0;
            bcnt_q  <= '0;
            shreg_q <= '0;
            done    <= 1'b0;
            data    <= '0;
            ferr    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    if (fall) begin
                        state_q <= RX_START;
                        tcnt_q  <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (tcnt_q == HALF_LAST) begin
                            tcnt_q  <= '0;
                            bcnt_q  <= '0;
                            state_q <= sync2_q ? RX_IDLE : RX_DATA;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (tcnt_q == SUB_LAST) begin
                            tcnt_q  <= '0;
                            shreg_q <= {sync2_q, shreg_q[DATA_W-1:1]};
                            if (bcnt_q == BIT_LAST) begin
                                state_q <= RX_STOP;
                            end else begin
                                bcnt_q <= bcnt_q + 1'b1;
                            end
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (tcnt_q == SUB_LAST) begin
                            tcnt_q  <= '0;
                            done    <= 1'b1;
                            data    <= shreg_q;
                            ferr    <= !sync2_q;
                            state_q <= RX_IDLE;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sio_fifo.sv
// Receive queue: DEPTH entries, head always visible on rdata. Assumes the
// caller never pushes when full nor pops when empty.
module sio_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       pop,
    output logic [DATA_W-1:0]          rdata,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  cnt_q;

    // Store incoming bytes at the write pointer
    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[wr_ptr_q] <= wdata;
        end
    end

    // Advance pointers and track occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) begin
                wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop) begin
                rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
            end
            if (push && !pop) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (pop && !push) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign rdata = mem_q[rd_ptr_q];
    assign count = cnt_q;

endmodule

// File: rtl/sio_port.sv
// Serial port top: register decode, status/control, error flags, interrupt.
// Assumes one bus strobe per cycle and word-aligned addresses; reads are
// combinational and a DATA read pops the queue at the clock edge.
module sio_port #(
    parameter logic [7:0] ID_B0    = 8'h53,
    parameter logic [7:0] ID_B1    = 8'h49,
    parameter logic [7:0] ID_B2    = 8'h4F,
    parameter logic [7:0] ID_B3    = 8'h01,
    parameter int         RX_DEPTH = 4,
    parameter int         OSR      = 4,
    parameter int         DIV_W    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       irq
);

    import sio_pkg::*;

    localparam int CNT_W = $clog2(RX_DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(RX_DEPTH);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(RX_DEPTH - 1);

    reg_sel_e          sel;
    logic              aligned;
    logic              wr_hit, rd_hit;
    logic              rx_ie_q, tx_ie_q, ferr_q, oerr_q;
    logic [DIV_W-1:0]  div_q;
    logic              tick;
    logic              tx_busy, tx_load;
    logic              rx_done, rx_ferr;
    logic [BYTE_W-1:0] rx_byte, head;
    logic [CNT_W-1:0]  fifo_count;
    logic              q_empty, q_full, push, pop;
    logic              stat_wr;
    logic [7:0]        status;

    assign sel     = reg_sel_e'(bus_addr[4:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_hit  = bus_wr && aligned;
    assign rd_hit  = bus_rd && aligned;

    assign q_empty = (fifo_count == '0);
    assign q_full  = (fifo_count == CNT_FULL);
    assign push    = rx_done && !q_full;
    assign pop     = rd_hit && (sel == SEL_DATA) && !q_empty;
    assign tx_load = wr_hit && (sel == SEL_DATA);
    assign stat_wr = wr_hit && (sel == SEL_STAT);

    sio_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (div_q),
        .tick    (tick)
    );

    sio_tx #(.DATA_W(BYTE_W), .OSR(OSR)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (tx_load),
        .load_data (bus_wdata),
        .busy      (tx_busy),
        .txd       (txd)
    );

    sio_rx #(.DATA_W(BYTE_W), .OSR(OSR)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .rxd   (rxd),
        .done  (rx_done),
        .data  (rx_byte),
        .ferr  (rx_ferr)
    );

    sio_fifo #(.DATA_W(BYTE_W), .DEPTH(RX_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (rx_byte),
        .pop   (pop),
        .rdata (head),
        .count (fifo_count)
    );

    // Divisor bytes: written through the low and high byte registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (wr_hit && sel == SEL_DIVLO) begin
            div_q[7:0] <= bus_wdata;
        end else if (wr_hit && sel == SEL_DIVHI) begin
            div_q[DIV_W-1:8] <= bus_wdata[DIV_W-9:0];
        end
    end

    // Interrupt enables take the written value on a status write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ie_q <= 1'b0;
            tx_ie_q <= 1'b0;
        end else if (stat_wr) begin
            rx_ie_q <= bus_wdata[ST_RXIE];
            tx_ie_q <= bus_wdata[ST_TXIE];
        end
    end

    // Sticky error flags: set by receive events, cleared by writing 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ferr_q <= 1'b0;
            oerr_q <= 1'b0;
        end else begin
            ferr_q <= (ferr_q && !(stat_wr && !bus_wdata[ST_FERR]))
                      || (rx_done && rx_ferr);
            oerr_q <= (oerr_q && !(stat_wr && !bus_wdata[ST_OERR]))
                      || (rx_done && q_full);
        end
    end

    // Assemble the status byte from live state
    always_comb begin
        status           = '0;
        status[ST_FERR]  = ferr_q;
        status[ST_OERR]  = oerr_q;
        status[ST_RXIE]  = rx_ie_q;
        status[ST_FULL]  = q_full;
        status[ST_ONE]   = (fifo_count == CNT_ONE);
        status[ST_EMPTY] = q_empty;
        status[ST_TXIE]  = tx_ie_q;
        status[ST_TXE]   = !tx_busy;
    end

    // Read multiplexer for the selected register
    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            unique case (sel)
                SEL_ID0:   bus_rdata = ID_B0;
                SEL_ID1:   bus_rdata = ID_B1;
                SEL_ID2:   bus_rdata = ID_B2;
                SEL_ID3:   bus_rdata = ID_B3;
                SEL_DATA:  bus_rdata = q_empty ? 8'h00 : head;
                SEL_STAT:  bus_rdata = status;
                SEL_DIVLO: bus_rdata = div_q[7:0];
                SEL_DIVHI: bus_rdata = 8'(div_q[DIV_W-1:8]);
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign irq = (rx_ie_q && (!q_empty || ferr_q || oerr_q)) || (tx_ie_q && !tx_busy);

endmodule

// Checker: protocol and state properties of the serial port, bound below.
// Assumes the bus never strobes read and write in the same cycle.
module sio_port_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       bus_addr,
    input logic             bus_wr,
    input logic [7:0]       bus_wdata,
    input logic             txd,
    input logic             irq,
    input logic             tx_busy,
    input logic             tx_ie_q,
    input logic             rx_ie_q,
    input logic             ferr_q,
    input logic             oerr_q,
    input logic             rx_done,
    input logic             rx_ferr,
    input logic [CNT_W-1:0] fifo_count
);

    logic st_wr;
    assign st_wr = bus_wr && (bus_addr == 5'd20);

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);  // R4

    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));  // R6

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && fifo_count == CNT_W'(DEPTH)) |=> oerr_q);  // R7

    AST_OVERRUN_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && fifo_count == CNT_W'(DEPTH) && !$isunknown(fifo_count)) |=> fifo_count <= CNT_W'(DEPTH));  // R7

    AST_FRAMING_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_ferr) |=> ferr_q);  // R8

    AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ferr_q && !(st_wr && !bus_wdata[0])) |=> ferr_q);  // R9

    AST_OERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (oerr_q && !(st_wr && !bus_wdata[1])) |=> oerr_q);  // R9

    AST_ENABLES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !st_wr |=> ($stable(rx_ie_q) && $stable(tx_ie_q)));  // R9

    AST_TX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ie_q && !tx_busy) |-> irq);  // R10

    AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ie_q && !rx_ie_q) |-> !irq);  // R10

endmodule

bind sio_port sio_port_chk #(.DEPTH(RX_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .txd        (txd),
    .irq        (irq),
    .tx_busy    (tx_busy),
    .tx_ie_q    (tx_ie_q),
    .rx_ie_q    (rx_ie_q),
    .ferr_q     (ferr_q),
    .oerr_q     (oerr_q),
    .rx_done    (rx_done),
    .rx_ferr    (rx_ferr),
    .fifo_count (fifo_count)
);

// File: tb/sio_port_tb.sv
// Directed bench for the serial port: one task per scenario, each checking
// its own results. Uses divisor 3, so one bit lasts 16 clocks.
module sio_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rxd = 1'b1;
    logic       txd;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam int BIT_CLK = 16;
    localparam logic [4:0] A_ID0 = 5'd0, A_ID1 = 5'd4, A_ID2 = 5'd8, A_ID3 = 5'd12;
    localparam logic [4:0] A_DATA = 5'd16, A_STAT = 5'd20, A_DLO = 5'd24, A_DHI = 5'd28;

    always #10 clk = ~clk;

    sio_port dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rxd       (rxd),
        .txd       (txd),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_bit);
        @(negedge clk);
        rxd = 1'b0;
        idle(BIT_CLK);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            idle(BIT_CLK);
        end
        rxd = stop_bit;
        idle(BIT_CLK);
        rxd = 1'b1;
        idle(2 * BIT_CLK);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 irq after reset", 16'(irq), 16'h0);
        check("R1 txd after reset", 16'(txd), 16'h1);
        bus_read(A_STAT, v);  check("R1 status after reset", 16'(v), 16'hA0);
        bus_read(A_DLO, v);   check("R1 divisor low", 16'(v), 16'h00);
        bus_read(A_DHI, v);   check("R1 divisor high", 16'(v), 16'h00);
    endtask

    task automatic t_ident();
        logic [7:0] v;
        bus_read(A_ID0, v); check("R2 id0", 16'(v), 16'h53);
        bus_read(A_ID1, v); check("R2 id1", 16'(v), 16'h49);
        bus_read(A_ID2, v); check("R2 id2", 16'(v), 16'h4F);
        bus_read(A_ID3, v); check("R2 id3", 16'(v), 16'h01);
        bus_write(A_ID0, 8'hEE);
        bus_read(A_ID0, v); check("R2 id0 after write", 16'(v), 16'h53);
        bus_write(5'd21, 8'h44);
        bus_read(A_STAT, v); check("R2 misaligned write ignored", 16'(v), 16'hA0);
    endtask

    task automatic t_divisor();
        logic [7:0] v;
        bus_write(A_DHI, 8'h12);
        bus_read(A_DHI, v); check("R3 divisor high readback", 16'(v), 16'h12);
        bus_write(A_DHI, 8'h00);
        bus_write(A_DLO, 8'h03);
        bus_read(A_DLO, v); check("R3 divisor low readback", 16'(v), 16'h03);
        bus_read(A_DHI, v); check("R3 divisor high cleared", 16'(v), 16'h00);
    endtask

    task automatic t_transmit();
        logic [7:0] v;
        logic [9:0] cap;
        int stray;
        bus_write(A_DATA, 8'hA5);
        idle(5);
        for (int k = 0; k < 10; k++) begin
            cap[k] = txd;
            if (k < 9) idle(BIT_CLK);
        end
        check("R4 frame bits", 16'(cap), 16'({1'b1, 8'hA5, 1'b0}));
        bus_read(A_STAT, v); check("R4 tx empty low while sending", 16'(v[7]), 16'h0);
        bus_write(A_DATA, 8'h0F);
        idle(2 * BIT_CLK);
        bus_read(A_STAT, v); check("R4 tx empty after stop", 16'(v[7]), 16'h1);
        stray = 0;
        for (int k = 0; k < 4 * BIT_CLK; k++) begin
            if (txd !== 1'b1) stray++;
            idle(1);
        end
        check("R4 write while busy ignored", 16'(stray), 16'h0);
    endtask

    task automatic t_receive();
        logic [7:0] v;
        send_frame(8'h3C, 1'b1);
        bus_read(A_STAT, v);  check("R5 status with one byte", 16'(v), 16'h80);
        bus_read(A_DATA, v);  check("R5 received byte", 16'(v), 16'h3C);
        bus_read(A_STAT, v);  check("R5 empty after pop", 16'(v), 16'hA0);
        bus_read(A_DATA, v);  check("R5 empty read returns 0", 16'(v), 16'h00);
        bus_read(A_STAT, v);  check("R5 empty read leaves queue", 16'(v), 16'hA0);
    endtask

    task automatic t_queue();
        logic [7:0] v;
        send_frame(8'h11, 1'b1);
        send_frame(8'h22, 1'b1);
        send_frame(8'h33, 1'b1);
        bus_read(A_STAT, v); check("R6 one space left", 16'(v), 16'h90);
        send_frame(8'h44, 1'b1);
        bus_read(A_STAT, v); check("R6 full", 16'(v), 16'h88);
        send_frame(8'h55, 1'b1);
        bus_read(A_STAT, v); check("R7 overrun flag", 16'(v), 16'h8A);
        bus_read(A_DATA, v); check("R7 order byte 0", 16'(v), 16'h11);
        bus_read(A_DATA, v); check("R7 order byte 1", 16'(v), 16'h22);
        bus_read(A_DATA, v); check("R7 order byte 2", 16'(v), 16'h33);
        bus_read(A_DATA, v); check("R7 order byte 3", 16'(v), 16'h44);
        bus_read(A_STAT, v); check("R7 dropped byte absent", 16'(v), 16'hA2);
        bus_write(A_STAT, 8'h00);
        bus_read(A_STAT, v); check("R9 overrun cleared by zero", 16'(v), 16'hA0);
    endtask

    task automatic t_framing();
        logic [7:0] v;
        send_frame(8'h5A, 1'b0);
        bus_read(A_STAT, v); check("R8 framing flag", 16'(v), 16'h81);
        bus_write(A_STAT, 8'h01);
        bus_read(A_STAT, v); check("R9 writing 1 keeps flag", 16'(v), 16'h81);
        bus_read(A_DATA, v); check("R8 byte still queued", 16'(v), 16'h5A);
        bus_write(A_STAT, 8'h00);
        bus_read(A_STAT, v); check("R9 framing cleared by zero", 16'(v), 16'hA0);
        bus_write(A_STAT, 8'hB8);
        bus_read(A_STAT, v); check("R9 read-only bits ignore write", 16'(v), 16'hA0);
    endtask

    task automatic t_interrupt();
        logic [7:0] v;
        send_frame(8'h77, 1'b1);
        check("R10 no irq with enables off", 16'(irq), 16'h0);
        bus_write(A_STAT, 8'h04);
        check("R10 rx irq with data", 16'(irq), 16'h1);
        bus_read(A_DATA, v);
        check("R10 rx irq clears when drained", 16'(irq), 16'h0);
        bus_write(A_STAT, 8'h40);
        check("R10 tx irq when empty", 16'(irq), 16'h1);
        bus_write(A_DATA, 8'h00);
        check("R10 tx irq low while busy", 16'(irq), 16'h0);
        idle(11 * BIT_CLK);
        check("R10 tx irq back after frame", 16'(irq), 16'h1);
        bus_write(A_STAT, 8'h00);
        check("R10 irq off after disable", 16'(irq), 16'h0);
    endtask

    task automatic t_glitch();
        logic [7:0] v;
        @(negedge clk);
        rxd = 1'b0;
        idle(4);
        rxd = 1'b1;
        idle(12 * BIT_CLK);
        bus_read(A_STAT, v); check("R11 short pulse queues nothing", 16'(v), 16'hA0);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_ident();
        t_divisor();
        t_transmit();
        t_receive();
        t_queue();
        t_framing();
        t_interrupt();
        t_glitch();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule